// File: doc/BRIEF.md
# Two-Beat Command/Address Decoder

This block sits behind the command/address pins of a DRAM device model or a memory-side agent. On each rising clock edge it samples an active-low select and a 14-bit command/address word. The low-order bits of a selected word form an opcode prefix.

Some commands are complete in that one word. These are the reference-voltage updates, the refresh family, the precharge forms and the multi-purpose command. Other commands carry an address and need a second word in the next cycle. These are activate, read, write, write-pattern and the two mode-register accesses. For them the block holds the first word and joins it with the second to form a 28-bit command. It then reports the command as a one-hot type vector and a set of decoded fields, all qualified by a single-cycle valid strobe.

Encodings that are reserved raise an illegal flag. A broken two-word sequence raises a protocol-error flag. The sequencer has two states. `ST_IDLE` waits for a first word. `ST_BEAT2` waits for the second word of an address-carrying command. The transitions are:

- `ST_IDLE` to `ST_BEAT2` on a selected, non-reserved first word that needs a second word.
- `ST_BEAT2` to `ST_IDLE` on completion, when select is low.
- `ST_BEAT2` to `ST_IDLE` on abort, when select is high.
- `ST_IDLE` stays in `ST_IDLE` in every other case.

Top module: `ca_cmd_decoder`

## Requirements
- R1: After an active-low reset all outputs are zero and any half-received command is discarded. A word that follows reset is decoded as a first word.
- R2: A cycle with `cs_n` high in `ST_IDLE` is a no-operation. It raises no valid, illegal or protocol flag, leaves every field output unchanged, and the `ca` value is ignored.
- R3: Single-word commands take CA0=1 and CA1=1, and the pattern {CA2,CA3,CA4} selects the command.
  - 000 is a reference-voltage update. The opcode is CA11..CA5, and CA13=1 selects the CS target (type bit 7) while CA13=0 selects the CA target (type bit 6).
  - 010 is a precharge. CA10=0 gives all banks (bit 12) and CA10=1 gives the same bank (bit 13) with bank=CA7..CA6.
  - 011 is a per-bank precharge (bit 14). Bank is CA7..CA6, bank group is CA10..CA8.
  - 110 is the multi-purpose command (bit 15) with opcode CA12..CA5.
  - Precharge chip ID is {CA5, CA13..CA11}.
  - `cmd_valid` is high in the cycle after the word is sampled.
- R4: Activate is a first word with CA0=0 and CA1=0 (type bit 0). Its fields are row bits 3..0 from CA5..CA2, bank from CA7..CA6, bank group from CA10..CA8 and chip ID bits 2..0 from CA13..CA11. The second word supplies row bits 17..4 from its CA13..CA0. `cmd_valid` is high in the cycle after the second word.
- R5: With CA0=1, CA1=0 and CA2=1, {CA3,CA4}=11 is read (bit 1) and 10 is write (bit 2). Burst flag is CA5, and bank, bank group and chip ID sit as in R4. CA2=0, CA3=1, CA4=0 and CA5=1 is write-pattern (bit 3), with bank, bank group and chip ID as in R4 and no burst flag. For all three, the column is CA10..CA0 of the second word.
- R6: With CA0=1, CA1=0 and CA2=1, {CA3,CA4}=00 is mode-register write (bit 4) and 01 is mode-register read (bit 5). The register address is CA12..CA5 of the first word. The write data is CA7..CA0 of the second word, and the second word of a read is ignored.
- R7: Refresh is {CA2,CA3,CA4}=001 with CA0=1 and CA1=1. CA9=1 selects all banks and CA9=0 selects the same bank, with bank=CA7..CA6. CA10=1 selects normal refresh and CA10=0 selects management refresh. Type bits: 8 is normal/all, 9 is normal/same, 10 is management/all and 11 is management/same. Chip ID is {CA5, CA13..CA11}.
- R8: A reserved first word raises `illegal` for exactly one cycle, in the cycle after it is sampled. It raises no `cmd_valid` and changes no field. Reserved first words are:
  - CA0=0 with CA1=1.
  - CA0=1, CA1=0, CA2=0 with anything other than CA3=1, CA4=0, CA5=1.
  - CA0=1, CA1=1 with {CA2,CA3,CA4} equal to 100, 101 or 111.
- R9: If `cs_n` is high in the cycle where a second word is due, the pending command is dropped. `proto_err` is high for one cycle after that cycle, with no `cmd_valid` and no field change. The next selected word is decoded as a first word.
- R10: `cmd_type` is one-hot while `cmd_valid` is high and zero otherwise. Fields that a command does not carry read zero. All fields hold their values while `cmd_valid` is low.
- R11: Commands may follow each other with no idle cycle. A first word sampled in the cycle after a completing word is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| ca | input | 14 | Command/address word |
| cmd_valid | output | 1 | Decoded command present this cycle |
| cmd_type | output | 16 | One-hot command type |
| bank | output | 2 | Bank address |
| bank_grp | output | 3 | Bank group |
| chip_id | output | 4 | Chip ID, bit 3 only for refresh/precharge |
| row | output | 18 | Row address |
| col | output | 11 | Column address |
| burst_flag | output | 1 | Burst-length flag of read/write |
| mr_addr | output | 8 | Mode-register address |
| opcode | output | 8 | Opcode or mode-register write data |
| illegal | output | 1 | Reserved encoding seen |
| proto_err | output | 1 | Second word missing, command dropped |

## Verification
The properties assume that `cs_n` and `ca` change only away from the rising edge. They also assume both inputs are known after reset, and that reset lasts at least one rising edge so no register starts unknown. The stimulus meets these assumptions by driving every input on the falling edge from a single process. It keeps `cs_n` high with known `ca` during reset, and it releases reset on a falling edge. Second words are always given known values, including the ones the decoder ignores, so that the hold and no-effect checks compare defined data.

// File: rtl/ca_cmd_pkg.sv
package ca_cmd_pkg;
    localparam int CA_W     = 14;
    localparam int BANK_W   = 2;
    localparam int BG_W     = 3;
    localparam int CID_W    = 4;
    localparam int ROW_LO_W = 4;
    localparam int ROW_W    = CA_W + ROW_LO_W;
    localparam int COL_W    = 11;
    localparam int MRA_W    = 8;
    localparam int OP_W     = 8;
    localparam int VREF_W   = 7;
    localparam int NCMD     = 16;

    typedef enum logic [3:0] {
        C_ACT  = 4'd0,
        C_RD   = 4'd1,
        C_WR   = 4'd2,
        C_WRP  = 4'd3,
        C_MRW  = 4'd4,
        C_MRR  = 4'd5,
        C_VRCA = 4'd6,
        C_VRCS = 4'd7,
        C_REFA = 4'd8,
        C_REFS = 4'd9,
        C_RFMA = 4'd10,
        C_RFMS = 4'd11,
        C_PREA = 4'd12,
        C_PRES = 4'd13,
        C_PREB = 4'd14,
        C_MPC  = 4'd15
    } cmd_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [BG_W-1:0]   bg;
        logic [CID_W-1:0]  cid;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              bl;
        logic [MRA_W-1:0]  mra;
        logic [OP_W-1:0]   op;
    } cmd_fields_t;
endpackage

// File: rtl/ca_beat_classify.sv
module ca_beat_classify
    import ca_cmd_pkg::*;
(
    input  logic [5:0] lead,     // CA5..CA0 of a first word
    input  logic [2:0] modbits,  // {CA13, CA10, CA9}
    output cmd_e       kind,
    output logic       two_beat,
    output logic       reserved
);
    logic [2:0] pat;
    assign pat = {lead[2], lead[3], lead[4]};

    always_comb begin
        kind     = C_ACT;
        two_beat = 1'b0;
        reserved = 1'b0;
        unique case (lead[1:0])
            2'b00: begin
                kind     = C_ACT;
                two_beat = 1'b1;
            end
            2'b10: reserved = 1'b1;
            2'b01: begin
                if (lead[2]) begin
                    two_beat = 1'b1;
                    unique case ({lead[3], lead[4]})
                        2'b00: kind = C_MRW;
                        2'b01: kind = C_MRR;
                        2'b10: kind = C_WR;
                        2'b11: kind = C_RD;
                    endcase
                end else if (lead[3] && !lead[4] && lead[5]) begin
                    kind     = C_WRP;
                    two_beat = 1'b1;
                end else begin
                    reserved = 1'b1;
                end
            end
            2'b11: begin
                unique case (pat)
                    3'b000: kind = modbits[2] ? C_VRCS : C_VRCA;
                    3'b001: begin
                        unique case (modbits[1:0])
                            2'b11: kind = C_REFA;
                            2'b10: kind = C_REFS;
                            2'b01: kind = C_RFMA;
                            2'b00: kind = C_RFMS;
                        endcase
                    end
                    3'b010: kind = modbits[1] ? C_PRES : C_PREA;
                    3'b011: kind = C_PREB;
                    3'b110: kind = C_MPC;
                    default: reserved = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/ca_field_unpack.sv
module ca_field_unpack
    import ca_cmd_pkg::*;
(
    input  cmd_e              kind,
    input  logic [CA_W-1:2]   first,
    input  logic [CA_W-1:0]   second,
    output cmd_fields_t       f
);
    logic [BANK_W-1:0] w_bank;
    logic [BG_W-1:0]   w_bg;
    logic [CID_W-1:0]  w_cid_lo;
    logic [CID_W-1:0]  w_cid_full;

    assign w_bank     = first[7:6];
    assign w_bg       = first[10:8];
    assign w_cid_lo   = {1'b0, first[13:11]};
    assign w_cid_full = {first[5], first[13:11]};

    always_comb begin
        f = '0;
        unique case (kind)
            C_ACT: begin
                f.bank = w_bank;
                f.bg   = w_bg;
                f.cid  = w_cid_lo;
                f.row  = {second, first[5:2]};
            end
            C_RD, C_WR: begin
                f.bank = w_bank;
                f.bg   = w_bg;
                f.cid  = w_cid_lo;
                f.bl   = first[5];
                f.col  = second[COL_W-1:0];
            end
            C_WRP: begin
                f.bank = w_bank;
                f.bg   = w_bg;
                f.cid  = w_cid_lo;
                f.col  = second[COL_W-1:0];
            end
            C_MRW: begin
                f.mra = first[12:5];
                f.op  = second[OP_W-1:0];
            end
            C_MRR:          f.mra = first[12:5];
            C_VRCA, C_VRCS: f.op  = {1'b0, first[5+VREF_W-1:5]};
            C_REFA, C_RFMA, C_PREA: f.cid = w_cid_full;
            C_REFS, C_RFMS, C_PRES: begin
                f.cid  = w_cid_full;
                f.bank = w_bank;
            end
            C_PREB: begin
                f.cid  = w_cid_full;
                f.bank = w_bank;
                f.bg   = w_bg;
            end
            C_MPC:          f.op  = first[12:5];
        endcase
    end
endmodule

// File: rtl/ca_cmd_decoder.sv
module ca_cmd_decoder
    import ca_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [CA_W-1:0]   ca,
    output logic              cmd_valid,
    output logic [NCMD-1:0]   cmd_type,
    output logic [BANK_W-1:0] bank,
    output logic [BG_W-1:0]   bank_grp,
    output logic [CID_W-1:0]  chip_id,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              burst_flag,
    output logic [MRA_W-1:0]  mr_addr,
    output logic [OP_W-1:0]   opcode,
    output logic              illegal,
    output logic              proto_err
);
    typedef enum logic {ST_IDLE, ST_BEAT2} seq_e;

    seq_e              state, state_nx;
    logic [CA_W-1:2]   held_ca;
    cmd_e              held_kind;

    cmd_e              cls_kind;
    logic              cls_two;
    logic              cls_rsv;

    cmd_e              sel_kind;
    logic [CA_W-1:2]   sel_first;
    cmd_fields_t       fld;

    logic              fire;
    logic              start_two;

    ca_beat_classify u_cls (
        .lead     (ca[5:0]),
        .modbits  ({ca[13], ca[10], ca[9]}),
        .kind     (cls_kind),
        .two_beat (cls_two),
        .reserved (cls_rsv)
    );

    always_comb begin
        sel_kind  = (state == ST_BEAT2) ? held_kind : cls_kind;
        sel_first = (state == ST_BEAT2) ? held_ca   : ca[CA_W-1:2];
    end

    ca_field_unpack u_unp (
        .kind   (sel_kind),
        .first  (sel_first),
        .second (ca),
        .f      (fld)
    );

    assign start_two = (state == ST_IDLE) && !cs_n && !cls_rsv && cls_two;
    assign fire      = ((state == ST_IDLE) && !cs_n && !cls_rsv && !cls_two)
                     || ((state == ST_BEAT2) && !cs_n);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_two) state_nx = ST_BEAT2;
            ST_BEAT2: state_nx = ST_IDLE;
        endcase
    end

    // state register and held first word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            held_ca   <= '0;
            held_kind <= C_ACT;
        end else begin
            state <= state_nx;
            if (start_two) begin
                held_ca   <= ca[CA_W-1:2];
                held_kind <= cls_kind;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_type   <= '0;
            bank       <= '0;
            bank_grp   <= '0;
            chip_id    <= '0;
            row        <= '0;
            col        <= '0;
            burst_flag <= 1'b0;
            mr_addr    <= '0;
            opcode     <= '0;
            illegal    <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            cmd_valid <= fire;
            illegal   <= (state == ST_IDLE) && !cs_n && cls_rsv;
            proto_err <= (state == ST_BEAT2) && cs_n;
            if (fire) begin
                cmd_type   <= NCMD'(1) << sel_kind;
                bank       <= fld.bank;
                bank_grp   <= fld.bg;
                chip_id    <= fld.cid;
                row        <= fld.row;
                col        <= fld.col;
                burst_flag <= fld.bl;
                mr_addr    <= fld.mra;
                opcode     <= fld.op;
            end else begin
                cmd_type   <= '0;
            end
        end
    end
endmodule

// File: rtl/ca_cmd_decoder_chk.sv
module ca_cmd_decoder_chk
    import ca_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cmd_valid,
    input logic [NCMD-1:0]   cmd_type,
    input logic [BANK_W-1:0] bank,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col,
    input logic [OP_W-1:0]   opcode,
    input logic              illegal,
    input logic              proto_err
);
    // R10
    type_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_type) == 1));

    // R10
    type_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_type == '0));

    // R10
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(row) && $stable(col) && $stable(bank) && $stable(opcode)));

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(cs_n));

    // R8
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!cmd_valid && !proto_err && !$past(cs_n)));

    // R9
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!cmd_valid && $past(cs_n)));
endmodule

bind ca_cmd_decoder ca_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .bank      (bank),
    .row       (row),
    .col       (col),
    .opcode    (opcode),
    .illegal   (illegal),
    .proto_err (proto_err)
);

// File: tb/ca_cmd_decoder_tb.sv
module ca_cmd_decoder_tb;
    import ca_cmd_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cs_n  = 1'b1;
    logic [13:0] ca    = 14'h0;

    logic        cmd_valid;
    logic [15:0] cmd_type;
    logic [1:0]  bank;
    logic [2:0]  bank_grp;
    logic [3:0]  chip_id;
    logic [17:0] row;
    logic [10:0] col;
    logic        burst_flag;
    logic [7:0]  mr_addr;
    logic [7:0]  opcode;
    logic        illegal;
    logic        proto_err;

    ca_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .bank(bank),
        .bank_grp(bank_grp), .chip_id(chip_id), .row(row), .col(col),
        .burst_flag(burst_flag), .mr_addr(mr_addr), .opcode(opcode),
        .illegal(illegal), .proto_err(proto_err)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0]  kind;
        logic [1:0]  bank;
        logic [2:0]  bg;
        logic [3:0]  cid;
        logic [17:0] row;
        logic [10:0] col;
        logic        bl;
        logic [7:0]  mra;
        logic [7:0]  op;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{5'd0,  2'd2, 3'd5, 4'h3, 18'h2A5C3, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd0,  2'd1, 3'd0, 4'h7, 18'h3FFFF, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd1,  2'd3, 3'd2, 4'h1, 18'h00000, 11'h7FF, 1'b1, 8'h00, 8'h00},
        '{5'd2,  2'd0, 3'd7, 4'h6, 18'h00000, 11'h123, 1'b0, 8'h00, 8'h00},
        '{5'd3,  2'd2, 3'd1, 4'h5, 18'h00000, 11'h456, 1'b0, 8'h00, 8'h00},
        '{5'd4,  2'd0, 3'd0, 4'h0, 18'h00000, 11'h000, 1'b0, 8'hA7, 8'h3C},
        '{5'd5,  2'd0, 3'd0, 4'h0, 18'h00000, 11'h000, 1'b0, 8'h5E, 8'h00},
        '{5'd6,  2'd0, 3'd0, 4'h0, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h55},
        '{5'd7,  2'd0, 3'd0, 4'h0, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h2A},
        '{5'd8,  2'd0, 3'd0, 4'hB, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd9,  2'd1, 3'd0, 4'h2, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd10, 2'd0, 3'd0, 4'h9, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd11, 2'd3, 3'd0, 4'h4, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd12, 2'd0, 3'd0, 4'hF, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd13, 2'd2, 3'd0, 4'h8, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd14, 2'd1, 3'd6, 4'hD, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00},
        '{5'd15, 2'd0, 3'd0, 4'h0, 18'h00000, 11'h000, 1'b0, 8'h00, 8'hC9},
        '{5'd1,  2'd0, 3'd0, 4'h0, 18'h00000, 11'h000, 1'b0, 8'h00, 8'h00}
    };

    localparam logic [13:0] RSV [7] = '{14'h0002, 14'h0001, 14'h0009, 14'h0019,
                                        14'h0007, 14'h0017, 14'h001F};

    // returns {two_beat, first word, second word} built from the requirement bit maps
    function automatic logic [28:0] enc(input vec_t v);
        logic [13:0] a;
        logic [13:0] b;
        logic        two;
        a = '0; b = '0; two = 1'b0;
        case (v.kind)
            5'd0: begin a = {v.cid[2:0], v.bg, v.bank, v.row[3:0], 2'b00};
                        b = v.row[17:4]; two = 1'b1; end
            5'd1, 5'd2: begin
                        a = {v.cid[2:0], v.bg, v.bank, v.bl, (v.kind == 5'd1), 1'b1, 1'b1, 1'b0, 1'b1};
                        b = {3'b000, v.col}; two = 1'b1; end
            5'd3: begin a = {v.cid[2:0], v.bg, v.bank, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
                        b = {3'b111, v.col}; two = 1'b1; end
            5'd4: begin a = {1'b0, v.mra, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
                        b = {6'h2A, v.op}; two = 1'b1; end
            5'd5: begin a = {1'b0, v.mra, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
                        b = 14'h3FFF; two = 1'b1; end
            5'd6, 5'd7: a = {(v.kind == 5'd7), 1'b0, v.op[6:0], 3'b000, 2'b11};
            5'd8, 5'd9, 5'd10, 5'd11:
                  a = {v.cid[2:0], (v.kind <= 5'd9), (v.kind == 5'd8 || v.kind == 5'd10),
                       1'b0, v.bank, v.cid[3], 3'b100, 2'b11};
            5'd12, 5'd13:
                  a = {v.cid[2:0], (v.kind == 5'd13), 2'b00, v.bank, v.cid[3], 3'b010, 2'b11};
            5'd14: a = {v.cid[2:0], v.bg, v.bank, v.cid[3], 3'b110, 2'b11};
            default: a = {1'b0, v.op, 3'b011, 2'b11};
        endcase
        return {two, a, b};
    endfunction

    function automatic string req_of(input logic [4:0] k);
        if (k == 5'd0) return "R4";
        if (k <= 5'd3) return "R5";
        if (k <= 5'd5) return "R6";
        if (k >= 5'd8 && k <= 5'd11) return "R7";
        return "R3";
    endfunction

    function automatic logic [54:0] exp_fields(input vec_t v);
        return {v.bank, v.bg, v.cid, v.row, v.col, v.bl, v.mra, v.op};
    endfunction

    function automatic logic [54:0] act_fields();
        return {bank, bank_grp, chip_id, row, col, burst_flag, mr_addr, opcode};
    endfunction

    // drive one command; returns at the falling edge where its result is visible
    task automatic send(input vec_t v);
        logic [28:0] e;
        e = enc(v);
        @(negedge clk);
        cs_n = 1'b0; ca = e[27:14];
        if (e[28]) begin
            @(negedge clk);
            ca = e[13:0];
        end
        @(negedge clk);
        cs_n = 1'b1; ca = 14'h2AAA;
    endtask

    task automatic chk_cmd(input string req, input vec_t v);
        chk(req, "valid", 64'(cmd_valid), 64'd1);
        chk(req, "type", 64'(cmd_type), 64'(16'd1 << v.kind));
        chk(req, "fields", 64'(act_fields()), 64'(exp_fields(v)));
        chk(req, "flags", 64'({illegal, proto_err}), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [54:0] keep;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "outputs in reset", 64'({cmd_valid, cmd_type, illegal, proto_err, act_fields()}), 64'd0);
        rst_n = 1'b1;

        // R2 deselect with activate-looking data on ca
        repeat (3) begin
            @(negedge clk);
            cs_n = 1'b1; ca = 14'h0000;
        end
        @(negedge clk);
        chk("R2", "deselect flags", 64'({cmd_valid, illegal, proto_err, cmd_type}), 64'd0);
        chk("R2", "deselect fields", 64'(act_fields()), 64'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            send(TBL[i]);
            chk_cmd(req_of(TBL[i].kind), TBL[i]);
            keep = act_fields();
            @(negedge clk);
            chk("R10", "valid drops", 64'({cmd_valid, cmd_type}), 64'd0);
            chk("R2", "hold across deselect", 64'(act_fields()), 64'(keep));
        end

        // R8 reserved first words
        send(TBL[16]);
        for (int i = 0; i < 7; i++) begin
            keep = act_fields();
            @(negedge clk);
            cs_n = 1'b0; ca = RSV[i];
            @(negedge clk);
            cs_n = 1'b1; ca = 14'h0000;
            chk("R8", "illegal raised", 64'({illegal, cmd_valid, proto_err}), 64'b100);
            chk("R8", "fields untouched", 64'(act_fields()), 64'(keep));
            @(negedge clk);
            chk("R8", "illegal one cycle", 64'(illegal), 64'd0);
        end

        // R9 missing second word
        keep = act_fields();
        @(negedge clk);
        cs_n = 1'b0; ca = enc(TBL[0])[27:14];
        @(negedge clk);
        cs_n = 1'b1; ca = 14'h1234;
        @(negedge clk);
        chk("R9", "abort flags", 64'({proto_err, cmd_valid, illegal}), 64'b100);
        chk("R9", "abort fields", 64'(act_fields()), 64'(keep));
        cs_n = 1'b0; ca = enc(TBL[16])[27:14];
        @(negedge clk);
        cs_n = 1'b1;
        chk("R9", "proto_err one cycle", 64'(proto_err), 64'd0);
        chk_cmd("R9", TBL[16]);

        // R11 back-to-back: read, per-bank precharge, multi-purpose
        @(negedge clk);
        cs_n = 1'b0; ca = enc(TBL[2])[27:14];
        @(negedge clk);
        ca = enc(TBL[2])[13:0];
        @(negedge clk);
        ca = enc(TBL[15])[27:14];
        chk_cmd("R11", TBL[2]);
        @(negedge clk);
        ca = enc(TBL[16])[27:14];
        chk_cmd("R11", TBL[15]);
        @(negedge clk);
        cs_n = 1'b1;
        chk_cmd("R11", TBL[16]);
        @(negedge clk);
        chk("R11", "idle after burst", 64'(cmd_valid), 64'd0);

        // R1 reset while a second word is pending
        @(negedge clk);
        cs_n = 1'b0; ca = enc(TBL[0])[27:14];
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "outputs after reset", 64'({cmd_valid, cmd_type, illegal, proto_err, act_fields()}), 64'd0);
        cs_n = 1'b0; ca = enc(TBL[16])[27:14];
        @(negedge clk);
        cs_n = 1'b1;
        chk_cmd("R1", TBL[16]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule